// File: doc/BRIEF.md
# Four-Word-Line Direct-Mapped Data Cache

This block is a direct-mapped data cache placed between a processor's single-word load/store port and a memory bus that moves one 32-bit word per transfer. It stores 1K words as 256 lines, each line holding a valid flag, a tag and four words. A request presents a byte address; the cache splits it into tag, line and word fields, checks the selected line, and on a match returns the word with no stall.

When the line does not match, the requester is held while the cache fetches all four words of the block from memory, one request at a time, and only then installs the new tag. Stores are written through to memory on every access. A store that misses first brings in the whole block and then merges the stored word, so a line never carries a new tag next to words of an older block.

The processor keeps `req`, `we`, `addr` and `wdata` steady while `stall` is high; a transfer completes in the cycle where `req` is high and `stall` is low, and `rdata` is meaningful in that cycle for loads.

Top module: `dcache_top`

## Requirements
- R1: The byte address is split as tag = bits [31:12], line = bits [11:4], word = bits [3:2]; bits [1:0] do not affect which word is returned.
- R2: A load hits when the selected line is valid and its stored tag equals bits [31:12]; a hit returns the word with `stall` low in the same cycle and issues no memory request.
- R3: After reset every line is invalid, so the first reference to any block misses and raises `stall`.
- R4: A load miss keeps `stall` high while it issues four memory reads, words 0, 1, 2, 3 of the block in that order, each at address {bits [31:4], word, 2'b00}, with one read outstanding at a time; the requested word is then returned.
- R5: A miss replaces the previous block of that line, so a later reference to the replaced block misses again; read data arrives only while the requester is stalled.
- R6: A store miss first refills all four words from memory and then merges the stored word; the other three words of the line equal memory afterwards.
- R7: Every store produces exactly one memory write carrying `wdata` at address {bits [31:2], 2'b00}, so a later load returns the stored value.
- R8: A store keeps `stall` high until its memory write is accepted (`mem_req_valid` and `mem_req_ready` both high).
- R9: A memory request that is not accepted stays asserted with the same address and direction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; invalidates all lines |
| req | input | 1 | Processor access request |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Store data |
| rdata | output | 32 | Load data, meaningful when `req` is high and `stall` low |
| stall | output | 1 | Holds the processor while the access cannot finish |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 32 | Word-aligned memory address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_resp_valid | input | 1 | Read data strobe from memory |
| mem_resp_data | input | 32 | Read data from memory |

## Verification
The bound checker watches every cycle for the handshake and stall rules: requests that stay stable under backpressure, refill reads aligned to the requested block, stores held until their write is taken, the write carrying the processor's address and data, and the first access after reset stalling. What only the bench scenarios can show is the content side: that refills arrive in word order 0 to 3, that a conflicting block evicts the old one, that a store miss leaves the other three words equal to memory, and that hits return the latest stored value under random mixes of loads, stores, offsets and memory latency.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    // Default geometry of the cache
    localparam int unsigned DC_ADDR_W     = 32;
    localparam int unsigned DC_WORD_W     = 32;
    localparam int unsigned DC_LINE_IDX_W = 8;
    localparam int unsigned DC_WORD_SEL_W = 2;
    localparam int unsigned DC_BYTE_SEL_W = 2;

    // Controller states
    typedef enum logic [1:0] {
        CS_LOOKUP    = 2'd0,
        CS_FILL_REQ  = 2'd1,
        CS_FILL_WAIT = 2'd2
    } ctrl_state_e;

    // Commands from the controller to the tag and data stores
    typedef struct packed {
        logic inv_line;      // drop valid at the start of a refill
        logic fill_word_we;  // write a returning refill word
        logic hit_word_we;   // merge a store into a resident line
        logic tag_we;        // install tag and valid after the last word
    } store_cmd_t;

    function automatic int unsigned tag_width(input int unsigned aw, input int unsigned lw,
                                              input int unsigned ww, input int unsigned bw);
        return aw - lw - ww - bw;
    endfunction

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
    parameter int unsigned LINE_IDX_W = 8,
    parameter int unsigned TAG_W      = 20,
    localparam int unsigned LINES     = 1 << LINE_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LINE_IDX_W-1:0] line,
    input  logic [TAG_W-1:0]      lookup_tag,
    input  logic                  set_en,
    input  logic                  clr_en,
    output logic                  hit
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[line] <= 1'b1;
        end else if (clr_en) begin
            valid_q[line] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[line] <= lookup_tag;
        end
    end

    assign hit = valid_q[line] && (tag_q[line] == lookup_tag);

endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
    parameter int unsigned LINE_IDX_W = 8,
    parameter int unsigned WORD_SEL_W = 2,
    parameter int unsigned WORD_W     = 32,
    localparam int unsigned LINES     = 1 << LINE_IDX_W,
    localparam int unsigned WORDS     = 1 << WORD_SEL_W
) (
    input  logic                  clk,
    input  logic [LINE_IDX_W-1:0] line,
    input  logic [WORD_SEL_W-1:0] rd_word,
    output logic [WORD_W-1:0]     rd_data,
    input  logic                  wr_en,
    input  logic [WORD_SEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0]     wr_data
);

    logic [WORD_W-1:0] lane_rd [WORDS];

    // One storage lane per word position of a line
    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        logic [WORD_W-1:0] lane_q [LINES];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_word == WORD_SEL_W'(g))) begin
                lane_q[line] <= wr_data;
            end
        end

        assign lane_rd[g] = lane_q[line];
    end

    assign rd_data = lane_rd[rd_word];

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int unsigned WORD_SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  we,
    input  logic                  hit,
    input  logic                  mem_req_ready,
    input  logic                  mem_resp_valid,
    output logic                  stall,
    output logic                  mem_req_valid,
    output logic                  mem_req_we,
    output logic [WORD_SEL_W-1:0] fill_word,
    output store_cmd_t            cmd
);

    localparam logic [WORD_SEL_W-1:0] LAST_WORD = '1;

    ctrl_state_e           state_q, state_d;
    logic [WORD_SEL_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_LOOKUP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d       = state_q;
        cnt_d         = cnt_q;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        cmd           = '0;
        case (state_q)
            CS_LOOKUP: begin
                if (req) begin
                    if (!hit) begin
                        // Miss on load or store: refill the whole line first
                        state_d      = CS_FILL_REQ;
                        cnt_d        = '0;
                        cmd.inv_line = 1'b1;
                    end else if (we) begin
                        // Store to a resident line: write through
                        mem_req_valid   = 1'b1;
                        mem_req_we      = 1'b1;
                        cmd.hit_word_we = mem_req_ready;
                    end
                end
            end
            CS_FILL_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) begin
                    state_d = CS_FILL_WAIT;
                end
            end
            CS_FILL_WAIT: begin
                if (mem_resp_valid) begin
                    cmd.fill_word_we = 1'b1;
                    if (cnt_q == LAST_WORD) begin
                        cmd.tag_we = 1'b1;
                        state_d    = CS_LOOKUP;
                    end else begin
                        cnt_d   = cnt_q + 1'b1;
                        state_d = CS_FILL_REQ;
                    end
                end
            end
            default: begin
                state_d = CS_LOOKUP;
            end
        endcase
    end

    assign stall     = req && !((state_q == CS_LOOKUP) && hit && (!we || mem_req_ready));
    assign fill_word = cnt_q;

endmodule

// File: rtl/dcache_top.sv
module dcache_top
    import dcache_pkg::*;
#(
    parameter int unsigned ADDR_W     = DC_ADDR_W,
    parameter int unsigned WORD_W     = DC_WORD_W,
    parameter int unsigned LINE_IDX_W = DC_LINE_IDX_W,
    parameter int unsigned WORD_SEL_W = DC_WORD_SEL_W,
    parameter int unsigned BYTE_SEL_W = DC_BYTE_SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              stall,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [WORD_W-1:0] mem_resp_data
);

    localparam int unsigned TAG_W    = tag_width(ADDR_W, LINE_IDX_W, WORD_SEL_W, BYTE_SEL_W);
    localparam int unsigned LINE_LSB = BYTE_SEL_W + WORD_SEL_W;
    localparam int unsigned TAG_LSB  = LINE_LSB + LINE_IDX_W;

    logic [TAG_W-1:0]      req_tag;
    logic [LINE_IDX_W-1:0] req_line;
    logic [WORD_SEL_W-1:0] req_word;
    logic                  unused_byte_bits;

    logic                  hit;
    logic [WORD_SEL_W-1:0] fill_word;
    store_cmd_t            cmd;

    logic                  data_we;
    logic [WORD_SEL_W-1:0] data_wr_word;
    logic [WORD_W-1:0]     data_wr_data;

    assign req_tag          = addr[ADDR_W-1:TAG_LSB];
    assign req_line         = addr[TAG_LSB-1:LINE_LSB];
    assign req_word         = addr[LINE_LSB-1:BYTE_SEL_W];
    assign unused_byte_bits = ^addr[BYTE_SEL_W-1:0];

    dcache_ctrl #(
        .WORD_SEL_W (WORD_SEL_W)
    ) ctrl_i (
        .clk            (clk),
        .rst            (rst),
        .req            (req),
        .we             (we),
        .hit            (hit),
        .mem_req_ready  (mem_req_ready),
        .mem_resp_valid (mem_resp_valid),
        .stall          (stall),
        .mem_req_valid  (mem_req_valid),
        .mem_req_we     (mem_req_we),
        .fill_word      (fill_word),
        .cmd            (cmd)
    );

    dcache_tag_store #(
        .LINE_IDX_W (LINE_IDX_W),
        .TAG_W      (TAG_W)
    ) tags_i (
        .clk        (clk),
        .rst        (rst),
        .line       (req_line),
        .lookup_tag (req_tag),
        .set_en     (cmd.tag_we),
        .clr_en     (cmd.inv_line),
        .hit        (hit)
    );

    assign data_we      = cmd.fill_word_we | cmd.hit_word_we;
    assign data_wr_word = cmd.fill_word_we ? fill_word : req_word;
    assign data_wr_data = cmd.fill_word_we ? mem_resp_data : wdata;

    dcache_data_store #(
        .LINE_IDX_W (LINE_IDX_W),
        .WORD_SEL_W (WORD_SEL_W),
        .WORD_W     (WORD_W)
    ) data_i (
        .clk     (clk),
        .line    (req_line),
        .rd_word (req_word),
        .rd_data (rdata),
        .wr_en   (data_we),
        .wr_word (data_wr_word),
        .wr_data (data_wr_data)
    );

    // Writes go to the addressed word; refill reads walk the block in order
    assign mem_req_addr  = mem_req_we
                         ? {addr[ADDR_W-1:BYTE_SEL_W], {BYTE_SEL_W{1'b0}}}
                         : {addr[ADDR_W-1:LINE_LSB], fill_word, {BYTE_SEL_W{1'b0}}};
    assign mem_req_wdata = wdata;

endmodule

// File: rtl/dcache_top_chk.sv
module dcache_top_chk
    import dcache_pkg::*;
#(
    parameter int unsigned ADDR_W     = DC_ADDR_W,
    parameter int unsigned WORD_W     = DC_WORD_W,
    parameter int unsigned BYTE_SEL_W = DC_BYTE_SEL_W,
    parameter int unsigned WORD_SEL_W = DC_WORD_SEL_W,
    localparam int unsigned LINE_LSB  = BYTE_SEL_W + WORD_SEL_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wdata,
    input logic              stall,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [WORD_W-1:0] mem_req_wdata,
    input logic              mem_resp_valid
);

    logic unused_chk_bits;
    assign unused_chk_bits = ^addr[BYTE_SEL_W-1:0];

    a_r3_cold_access_stalls: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && req |-> stall);

    a_r4_fill_holds_requester: assert property (@(posedge clk) disable iff (rst)
        req && mem_req_valid && !mem_req_we |-> stall);

    a_r4_fill_addr_in_block: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_we |->
            (mem_req_addr[BYTE_SEL_W-1:0] == '0) &&
            (mem_req_addr[ADDR_W-1:LINE_LSB] == addr[ADDR_W-1:LINE_LSB]));

    a_r5_resp_only_when_stalled: assert property (@(posedge clk) disable iff (rst)
        mem_resp_valid |-> stall);

    a_r7_write_payload: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_we |->
            req && we && (mem_req_wdata == wdata) &&
            (mem_req_addr[ADDR_W-1:BYTE_SEL_W] == addr[ADDR_W-1:BYTE_SEL_W]));

    a_r8_store_waits_accept: assert property (@(posedge clk) disable iff (rst)
        req && mem_req_valid && mem_req_we && !mem_req_ready |-> stall);

    a_r9_request_held: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

endmodule

bind dcache_top dcache_top_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .req            (req),
    .we             (we),
    .addr           (addr),
    .wdata          (wdata),
    .stall          (stall),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_we     (mem_req_we),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_resp_valid (mem_resp_valid)
);

// File: tb/dcache_top_tb_top.sv
module dcache_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req, we;
    logic [31:0] addr, wdata, rdata;
    logic        stall;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_data;

    always #5 clk = ~clk;

    dcache_top dut_i (
        .clk            (clk),
        .rst            (rst),
        .req            (req),
        .we             (we),
        .addr           (addr),
        .wdata          (wdata),
        .rdata          (rdata),
        .stall          (stall),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_we     (mem_req_we),
        .mem_req_addr   (mem_req_addr),
        .mem_req_wdata  (mem_req_wdata),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data)
    );

    int checks = 0;
    int errors = 0;

    function automatic void chk(input bit ok, input string rq, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endfunction

    // ---------------- memory model (only this process writes its state) -----
    logic [31:0] bmem [logic [31:0]];
    int          rd_total = 0;
    int          wr_total = 0;
    logic [31:0] rd_hist [4];
    logic [31:0] last_wr_addr;
    int          nedge = 0;
    int          lo_start = -1;   // written by the main process only
    int          lo_len = 0;
    bit          rand_ready = 1'b1;

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (bmem.exists(a)) return bmem[a];
        return (a * 32'h9E37_79B9) ^ 32'h5A5A_1234;
    endfunction

    initial begin
        bit          pend = 1'b0;
        int          lat = 0;
        logic [31:0] pend_addr = '0;
        mem_req_ready  = 1'b0;
        mem_resp_valid = 1'b0;
        mem_resp_data  = '0;
        forever begin
            @(negedge clk);
            nedge++;
            mem_resp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = mem_rd(pend_addr);
                    pend = 1'b0;
                end else begin
                    lat--;
                end
            end
            if (nedge >= lo_start && nedge < lo_start + lo_len) mem_req_ready = 1'b0;
            else if (pend)                                       mem_req_ready = 1'b0;
            else if (rand_ready)                                 mem_req_ready = (($urandom % 4) != 0);
            else                                                 mem_req_ready = 1'b1;
            #1;
            if (!rst && mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    bmem[mem_req_addr] = mem_req_wdata;
                    last_wr_addr = mem_req_addr;
                    wr_total++;
                end else begin
                    rd_hist[rd_total % 4] = mem_req_addr;
                    rd_total++;
                    pend = 1'b1;
                    pend_addr = mem_req_addr;
                    lat = $urandom % 3;
                end
            end
        end
    end

    // ---------------- processor side -------------------------------------
    bit          exp_valid [256];
    logic [19:0] exp_tag   [256];

    task automatic access(input bit w, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int cyc, output int nrd,
                          output int nwr, output int rd0);
        int r_start, w_start;
        @(negedge clk);
        r_start = rd_total;
        w_start = wr_total;
        req = 1'b1; we = w; addr = a; wdata = d;
        cyc = 0;
        #2;
        while (stall) begin
            @(negedge clk);
            #2;
            cyc++;
            if (cyc > 500) begin
                chk(1'b0, "WDOG", "access hung", 32'(cyc), 32'd0);
                break;
            end
        end
        rd = rdata;
        @(posedge clk);
        #1;
        req = 1'b0; we = 1'b0;
        nrd = rd_total - r_start;
        nwr = wr_total - w_start;
        rd0 = r_start;
    endtask

    task automatic check_fill_order(input logic [31:0] a, input int rd0, input string rq);
        for (int k = 0; k < 4; k++) begin
            chk(rd_hist[(rd0 + k) % 4] == {a[31:4], 2'(k), 2'b00}, rq,
                "refill word order", rd_hist[(rd0 + k) % 4], {a[31:4], 2'(k), 2'b00});
        end
    endtask

    task automatic do_read(input logic [31:0] a, output bit was_hit, output int cyc);
        logic [31:0] rd;
        int nrd, nwr, rd0;
        bit exp_hit = exp_valid[a[11:4]] && (exp_tag[a[11:4]] == a[31:12]);
        access(1'b0, a, 32'd0, rd, cyc, nrd, nwr, rd0);
        was_hit = (cyc == 0);
        chk(rd == mem_rd({a[31:2], 2'b00}), exp_hit ? "R2" : "R4", "load data",
            rd, mem_rd({a[31:2], 2'b00}));
        if (exp_hit) begin
            chk(cyc == 0 && nrd == 0, "R2", "hit without stall or refill", 32'(cyc), 32'd0);
        end else begin
            chk(cyc > 0, "R4", "miss stalls", 32'(cyc), 32'd1);
            chk(nrd == 4, "R4", "refill read count", 32'(nrd), 32'd4);
            if (nrd == 4) check_fill_order(a, rd0, "R4");
        end
        chk(nwr == 0, "R2", "load issues no write", 32'(nwr), 32'd0);
        exp_valid[a[11:4]] = 1'b1;
        exp_tag[a[11:4]]   = a[31:12];
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, output int cyc);
        logic [31:0] rd;
        int nrd, nwr, rd0;
        bit exp_hit = exp_valid[a[11:4]] && (exp_tag[a[11:4]] == a[31:12]);
        access(1'b1, a, d, rd, cyc, nrd, nwr, rd0);
        if (exp_hit) begin
            chk(nrd == 0, "R7", "store hit needs no refill", 32'(nrd), 32'd0);
        end else begin
            chk(nrd == 4, "R6", "store miss refills line", 32'(nrd), 32'd4);
            if (nrd == 4) check_fill_order(a, rd0, "R6");
        end
        chk(nwr == 1, "R7", "one memory write per store", 32'(nwr), 32'd1);
        chk(last_wr_addr == {a[31:2], 2'b00}, "R7", "write address", last_wr_addr,
            {a[31:2], 2'b00});
        chk(mem_rd({a[31:2], 2'b00}) == d, "R7", "memory holds stored word",
            mem_rd({a[31:2], 2'b00}), d);
        exp_valid[a[11:4]] = 1'b1;
        exp_tag[a[11:4]]   = a[31:12];
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL WDOG global timeout actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit   h;
        int   c;
        logic [31:0] a_base, b_conf, c_st;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            exp_valid[i] = 1'b0;
            exp_tag[i]   = '0;
        end
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        chk(stall == 1'b0, "R3", "stall low in reset", 32'(stall), 32'd0);
        chk(mem_req_valid == 1'b0, "R3", "no memory request in reset", 32'(mem_req_valid), 32'd0);
        rst = 1'b0;

        a_base = 32'h0001_2340;   // tag 0x00012, line 0x34, word 0
        b_conf = 32'h0001_3340;   // same line, different tag
        c_st   = 32'h0005_6788;   // line 0x78, word 2

        // R3: cold reference misses; R4: full ordered refill
        do_read(a_base, h, c);
        chk(!h, "R3", "first reference misses", 32'(h), 32'd0);
        // R1: same line, other word, byte bits set -> hit
        do_read(a_base | 32'h7, h, c);
        chk(h, "R1", "byte offset ignored, same block hits", 32'(h), 32'd1);
        // R1: same line index, new tag -> conflict miss
        do_read(b_conf, h, c);
        chk(!h, "R1", "tag compare on bits 31:12", 32'(h), 32'd0);
        // R5: evicted block misses again
        do_read(a_base, h, c);
        chk(!h, "R5", "replaced block misses", 32'(h), 32'd0);

        // R8: store hit held while memory refuses for three cycles
        rand_ready = 1'b0;
        lo_start = nedge + 1;
        lo_len   = 3;
        do_write(a_base | 32'h8, 32'hCAFE_0008, c);
        chk(c == 3, "R8", "store stalls until write accepted", 32'(c), 32'd3);
        lo_len = 0;
        do_read(a_base | 32'h8, h, c);
        chk(h, "R7", "stored word hits", 32'(h), 32'd1);

        // R6: store miss refills then merges
        do_write(c_st, 32'h1234_ABCD, c);
        do_read(c_st & ~32'hC, h, c);
        chk(h, "R6", "word 0 of merged line resident", 32'(h), 32'd1);
        do_read(c_st | 32'h4, h, c);
        chk(h, "R6", "word 3 of merged line resident", 32'(h), 32'd1);
        do_read(c_st, h, c);
        chk(h, "R6", "merged word resident", 32'(h), 32'd1);

        // Random mix with random backpressure and latency
        rand_ready = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra;
            ra = {20'h00040 + 20'($urandom % 4), 8'($urandom % 8), 2'($urandom % 4),
                  2'($urandom % 4)};
            if (($urandom % 2) == 0) do_read(ra, h, c);
            else                     do_write(ra, $urandom, c);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule